// File: doc/BRIEF.md
# Sync Character Stripper

This block sits in the receive path of a character-oriented synchronous receiver, between the character assembler and the receive FIFO and its CRC unit. Each assembled character arrives as a byte with a one-cycle valid strobe. The block compares the byte with a programmed sync value. When stripping is enabled, it keeps characters equal to that value out of the FIFO and out of the CRC. Every other character is forwarded with a FIFO write strobe and a CRC-include strobe in the same cycle as its valid.

For a monosync line with the six-bit sync option, stripping is not total. The block retains the latest sync character. That character is released just ahead of the next non-sync character, so the sync directly before the data survives. The released sync goes out in the cycle of the data byte's valid, and the data byte follows one cycle later. Because of this, valid strobes must be at least one idle cycle apart. An assembler that builds characters serially always meets this.

Stripping never applies in bisync with the six-bit option, in the bit-oriented frame mode, or in the reserved mode. A start-of-data flag marks a character as data even when it equals the sync value.

Top module: `sync_strip`

## Requirements
- R1: With `strip_en`=1 and either `mode`=0 (monosync) and `six_bit`=0, or `mode`=1 (bisync) and `six_bit`=0, a valid byte equal to `sync_byte` produces neither `fifo_we` nor `crc_inc`.
- R2: `crc_inc` is high in exactly the cycles where `fifo_we` is high.
- R3: A valid byte that is not removed, and not delayed by R5, is output on `fifo_data` with `fifo_we` in its own valid cycle. With `strip_en`=0, every byte passes in this way.
- R4: The sync comparison uses all eight bits in every mode, including monosync with `six_bit`=1. A byte that differs from `sync_byte` only in bit 7 is treated as data.
- R5: With `strip_en`=1, `mode`=0 and `six_bit`=1, a matching byte is held rather than output, and a newer match replaces an older one. When a non-matching byte arrives with a sync held, the held sync is output in that valid cycle and the data byte is output in the next cycle. When no sync is held, a non-matching byte passes as in R3.
- R6: In `mode`=1 with `six_bit`=1, `strip_en` has no effect and every byte passes as in R3.
- R7: In `mode`=2 (bit-oriented frames) and in `mode`=3 (reserved), `strip_en` has no effect and every byte passes as in R3.
- R8: A byte presented with `start_of_data`=1 is treated as data even when it equals `sync_byte`.
- R9: Reset, or `rx_en`=0, discards any held sync and any pending output. While `rx_en`=0, input bytes are ignored and both strobes stay low.
- R10: Leaving the R5 configuration discards a held sync, so it is never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low clears and silences the block |
| in_valid | input | 1 | One-cycle strobe for an assembled character |
| in_byte | input | 8 | Assembled character |
| sync_byte | input | 8 | Programmed sync compare value |
| strip_en | input | 1 | Sync strip control |
| mode | input | 2 | 0 monosync, 1 bisync, 2 bit-oriented frames, 3 reserved |
| six_bit | input | 1 | Six-bit sync option |
| start_of_data | input | 1 | Marks the present character as data |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Character written to the FIFO |
| crc_inc | output | 1 | Include the character in the CRC |

## Verification
Each forwarded character is due at the falling edge of its own valid cycle. The one exception is a data byte released behind a held sync: there the held sync is due in the valid cycle and the data byte one cycle later. Inputs are driven just after a rising edge, and outputs are sampled at the following falling edge. A scoreboard queue of expected bytes checks both order and content. Removed or ignored characters push nothing, so any unexpected strobe is a failure, and each scenario ends with a check that the queue has drained.

// File: rtl/sync_strip_pkg.sv
package sync_strip_pkg;
  typedef enum logic [1:0] {
    MODE_MONO   = 2'd0,
    MODE_BISYNC = 2'd1,
    MODE_FRAME  = 2'd2,
    MODE_RSVD   = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/sync_strip_policy.sv
module sync_strip_policy
  import sync_strip_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] in_byte,
  input  logic [W-1:0] sync_byte,
  input  logic         strip_en,
  input  logic [1:0]   mode,
  input  logic         six_bit,
  input  logic         start_of_data,
  output logic         is_sync,
  output logic         drop_mode,
  output logic         hold_mode
);
  rx_mode_e mode_e;
  logic     full_match;

  always_comb begin
    mode_e = rx_mode_e'(mode);
    // Full-width compare regardless of the six-bit option.
    full_match = (in_byte == sync_byte);
    is_sync    = full_match && !start_of_data;
    drop_mode  = 1'b0;
    hold_mode  = 1'b0;
    unique case (mode_e)
      MODE_MONO: begin
        drop_mode = strip_en && !six_bit;
        hold_mode = strip_en && six_bit;
      end
      MODE_BISYNC: begin
        drop_mode = strip_en && !six_bit;
      end
      default: begin
        drop_mode = 1'b0;
        hold_mode = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sync_strip_hold.sv
module sync_strip_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         take,
  input  logic         is_sync,
  input  logic         hold_mode,
  input  logic [W-1:0] in_byte,
  output logic         held_v,
  output logic [W-1:0] held_byte,
  output logic         pend_v,
  output logic [W-1:0] pend_byte,
  output logic         release_now
);
  logic         held_v_n;
  logic [W-1:0] held_byte_n;
  logic         pend_v_n;
  logic [W-1:0] pend_byte_n;
  logic         held_ce;
  logic         pend_ce;

  always_comb begin
    release_now = rx_en && hold_mode && take && !is_sync && held_v;
    held_v_n    = held_v;
    held_byte_n = held_byte;
    held_ce     = 1'b0;
    if (!rx_en || !hold_mode) begin
      held_v_n = 1'b0;
    end else if (take && is_sync) begin
      held_v_n    = 1'b1;
      held_byte_n = in_byte;
      held_ce     = 1'b1;
    end else if (release_now) begin
      held_v_n = 1'b0;
    end
    pend_v_n    = rx_en && release_now;
    pend_byte_n = in_byte;
    pend_ce     = release_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      pend_v <= 1'b0;
    end else begin
      held_v <= held_v_n;
      pend_v <= pend_v_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_byte <= '0;
    end else if (held_ce) begin
      held_byte <= held_byte_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_byte <= '0;
    end else if (pend_ce) begin
      pend_byte <= pend_byte_n;
    end
  end

  // Environment rule: a released data byte needs one idle cycle to leave.
  assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> !take);
endmodule

// File: rtl/sync_strip_out.sv
module sync_strip_out #(
  parameter int W = 8
) (
  input  logic         rx_en,
  input  logic         take,
  input  logic [W-1:0] in_byte,
  input  logic         is_sync,
  input  logic         drop_mode,
  input  logic         hold_mode,
  input  logic         held_v,
  input  logic [W-1:0] held_byte,
  input  logic         pend_v,
  input  logic [W-1:0] pend_byte,
  output logic         we,
  output logic [W-1:0] data
);
  always_comb begin
    we   = 1'b0;
    data = in_byte;
    if (rx_en) begin
      if (pend_v) begin
        we   = 1'b1;
        data = pend_byte;
      end else if (take) begin
        if (hold_mode) begin
          we   = !is_sync;
          data = held_v ? held_byte : in_byte;
        end else begin
          we   = !(drop_mode && is_sync);
          data = in_byte;
        end
      end
    end
  end
endmodule

// File: rtl/sync_strip.sv
module sync_strip
  import sync_strip_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         in_valid,
  input  logic [W-1:0] in_byte,
  input  logic [W-1:0] sync_byte,
  input  logic         strip_en,
  input  logic [1:0]   mode,
  input  logic         six_bit,
  input  logic         start_of_data,
  output logic         fifo_we,
  output logic [W-1:0] fifo_data,
  output logic         crc_inc
);
  logic         take;
  logic         is_sync;
  logic         drop_mode;
  logic         hold_mode;
  logic         held_v;
  logic [W-1:0] held_byte;
  logic         pend_v;
  logic [W-1:0] pend_byte;
  logic         release_now;
  logic         we;

  assign take = in_valid && rx_en;

  sync_strip_policy #(.W(W)) u_policy (
    .in_byte(in_byte), .sync_byte(sync_byte), .strip_en(strip_en),
    .mode(mode), .six_bit(six_bit), .start_of_data(start_of_data),
    .is_sync(is_sync), .drop_mode(drop_mode), .hold_mode(hold_mode)
  );

  sync_strip_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .take(take),
    .is_sync(is_sync), .hold_mode(hold_mode), .in_byte(in_byte),
    .held_v(held_v), .held_byte(held_byte), .pend_v(pend_v),
    .pend_byte(pend_byte), .release_now(release_now)
  );

  sync_strip_out #(.W(W)) u_out (
    .rx_en(rx_en), .take(take), .in_byte(in_byte), .is_sync(is_sync),
    .drop_mode(drop_mode), .hold_mode(hold_mode), .held_v(held_v),
    .held_byte(held_byte), .pend_v(pend_v), .pend_byte(pend_byte),
    .we(we), .data(fifo_data)
  );

  assign fifo_we = we;
  assign crc_inc = we;

  assert_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && drop_mode && (in_byte == sync_byte) && !start_of_data && !pend_v)
      |-> !fifo_we);

  assert_release_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> (!rx_en || (fifo_we && fifo_data == $past(in_byte))));

  assert_bisync_six_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == 2'd1 && six_bit && !pend_v)
      |-> (fifo_we && fifo_data == in_byte));

  assert_frame_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode[1] && !pend_v) |-> (fifo_we && fifo_data == in_byte));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!fifo_we && !crc_inc));
endmodule

// File: tb/sync_strip_bench.sv
module sync_strip_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, in_valid, strip_en, six_bit, start_of_data;
  logic [7:0] in_byte, sync_byte;
  logic [1:0] mode;
  logic       fifo_we, crc_inc;
  logic [7:0] fifo_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R9";

  always #5 clk = ~clk;

  sync_strip u_sync_strip (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_byte(in_byte), .sync_byte(sync_byte), .strip_en(strip_en),
    .mode(mode), .six_bit(six_bit), .start_of_data(start_of_data),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .crc_inc(crc_inc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
    tag_q.push_back(cur_tag);
  endtask

  task automatic send(input logic [7:0] b, input logic sod);
    @(posedge clk); #2;
    in_byte = b; start_of_data = sod; in_valid = 1'b1;
    @(posedge clk); #2;
    in_valid = 1'b0; start_of_data = 1'b0;
  endtask

  task automatic drain;
    repeat (3) @(posedge clk);
    #2;
    chk(exp_q.size() == 0, {cur_tag, " drain"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic cfg(input logic se, input logic [1:0] md, input logic sb);
    @(posedge clk); #2;
    strip_en = se; mode = md; six_bit = sb;
  endtask

  // Scoreboard monitor, sampling at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_we !== crc_inc)
        chk(1'b0, "R2 strobe pairing", crc_inc, fifo_we);
      if (fifo_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected write"}, fifo_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(fifo_data == e && crc_inc, t, fifo_data, e);
        end
      end
    end
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
    sync_byte = 8'h16; strip_en = 1'b0; mode = 2'd0; six_bit = 1'b0;
    start_of_data = 1'b0;
    repeat (3) @(negedge clk);
    chk(!fifo_we && !crc_inc, "R9 reset quiet", fifo_we, 0);
    @(posedge clk); #2; rst_n = 1'b1;

    cur_tag = "R3";
    expect_byte(8'h16); send(8'h16, 1'b0);
    expect_byte(8'h41); send(8'h41, 1'b0);
    drain();

    cur_tag = "R1";
    cfg(1'b1, 2'd0, 1'b0);
    send(8'h16, 1'b0);
    expect_byte(8'h41); send(8'h41, 1'b0);
    send(8'h16, 1'b0);
    expect_byte(8'h42); send(8'h42, 1'b0);
    drain();

    cur_tag = "R8";
    expect_byte(8'h16); send(8'h16, 1'b1);
    drain();

    cur_tag = "R4";
    cfg(1'b1, 2'd0, 1'b1);
    expect_byte(8'h96); send(8'h96, 1'b0);
    expect_byte(8'h56); send(8'h56, 1'b0);
    drain();

    cur_tag = "R5";
    send(8'h16, 1'b0); send(8'h16, 1'b0); send(8'h16, 1'b0);
    expect_byte(8'h16); expect_byte(8'h41); send(8'h41, 1'b0);
    expect_byte(8'h43); send(8'h43, 1'b0);
    send(8'h16, 1'b0);
    expect_byte(8'h16); expect_byte(8'h42); send(8'h42, 1'b0);
    drain();

    cur_tag = "R10";
    send(8'h16, 1'b0);
    cfg(1'b1, 2'd0, 1'b0);
    expect_byte(8'h41); send(8'h41, 1'b0);
    drain();

    cur_tag = "R6";
    cfg(1'b1, 2'd1, 1'b1);
    expect_byte(8'h16); send(8'h16, 1'b0);
    expect_byte(8'h41); send(8'h41, 1'b0);
    drain();

    cur_tag = "R1";
    cfg(1'b1, 2'd1, 1'b0);
    send(8'h16, 1'b0);
    expect_byte(8'h44); send(8'h44, 1'b0);
    drain();

    cur_tag = "R7";
    cfg(1'b1, 2'd2, 1'b0);
    expect_byte(8'h16); send(8'h16, 1'b0);
    cfg(1'b1, 2'd3, 1'b1);
    expect_byte(8'h16); send(8'h16, 1'b0);
    expect_byte(8'h45); send(8'h45, 1'b0);
    drain();

    cur_tag = "R9";
    cfg(1'b1, 2'd0, 1'b1);
    send(8'h16, 1'b0);
    @(posedge clk); #2; rx_en = 1'b0;
    send(8'h55, 1'b0);
    @(posedge clk); #2; rx_en = 1'b1;
    expect_byte(8'h41); send(8'h41, 1'b0);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule